// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a 16-bit general-purpose timer that counts prescaled clock ticks. A free-running divider makes one tick every 2^k clock cycles, where k is a 3-bit select. On each tick the counter steps once. It runs in one of two modes. In saw-tooth mode it counts upward and wraps to zero after reaching the period value. In triangle mode it climbs to the period value and then falls back to zero. From the count it builds a compare waveform: asymmetric in saw-tooth mode and symmetric in triangle mode. It also gives a one-clock pulse each time the count arrives at the period value. The running count is a plain output, so a capture stage can sample it as a time base.

The period and compare inputs are used directly while the count is zero. When the count leaves zero their values are latched into holding registers, and those held values stay in force until the count is back at zero. The holding registers come out of reset at all ones. The counting mode is fixed when the timer leaves its idle state. The control is a four-state machine:
- IDLE: disabled, count zero.
- UP: saw-tooth counting.
- RISE: triangle mode, counting upward.
- FALL: triangle mode, counting downward.

Its transitions are:
- IDLE→UP or IDLE→RISE: taken on the first clock with enable high, chosen by the mode input.
- RISE→FALL: taken on the tick at the period value, when the next count is not zero.
- FALL→RISE: taken on the tick that brings the count down to zero.
- Any state→IDLE: taken on any clock with enable low.

All outputs are registered. A tick changes them at the clock edge that ends the tick's cycle.

Top module: `gp_timer_cmp`

## Requirements
- R1: A prescale code k (0 to 7) makes the count step once every 2^k clock cycles. The divider starts from zero when the timer leaves IDLE, so the first step lands 2^k clocks after the IDLE exit edge. Between steps the count holds.
- R2: With the mode input low (saw-tooth), the count steps 0,1,…,P and then returns to 0, where P is the period in force. With P = 0 the count stays at 0.
- R3: With the mode input high (triangle), the count steps 0,1,…,P,P-1,…,1,0,1,… and reverses at P and at 0. With P = 1 it alternates between 0 and 1. With P = 0 it stays at 0.
- R4: In saw-tooth mode, after each step the compare output is 1 exactly when the count is nonzero and at least C, the compare value in force. So it rises when the climbing count reaches C and falls at the wrap to 0.
- R5: In triangle mode, after an upward step the compare output is 1 when the count is nonzero and at least C. After a downward step it is 1 only when the count is greater than C. So it rises when the climbing count reaches C and falls when the falling count reaches C.
- R6: The period-event output is 1 for exactly one clock after any step (or stationary tick) whose resulting count equals P, and 0 otherwise.
- R7: The period and compare inputs take effect only while the count is 0. Changes made while the count is nonzero leave the current cycle unchanged.
- R8: The mode input is sampled only when leaving IDLE. Changing it while enabled has no effect.
- R9: With enable low, the next clock edge clears the count, the compare output, the period event and the prescale divider, and keeps them cleared. After enable returns high, one edge enters the counting state.
- R10: During and right after reset, the count, compare output and period event are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the timer; low returns to IDLE |
| prescale_sel | input | 3 | Divider code k, tick every 2^k clocks |
| period_in | input | 16 | Period value P |
| compare_in | input | 16 | Compare value C |
| updown_mode | input | 1 | 0 saw-tooth, 1 triangle |
| count_out | output | 16 | Running count |
| cmp_out | output | 1 | Compare waveform |
| period_evt | output | 1 | One-clock pulse on reaching P |

## Verification
The assertions assume that reset is applied before enable is first raised. They also assume that the prescale code, period and compare inputs are stable, or change only in ways R7 allows, while the count is nonzero. The bound check on the saw-tooth count relies on the period being latched at zero. The stimulus changes every configuration input with enable low, on a falling clock edge. The only exceptions are the deliberate mid-run changes to period, compare and mode, which are made while the count is nonzero to show that they are held off.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_RISE = 2'd2,
        ST_FALL = 2'd3
    } tmr_state_e;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // mask has sel low bits set; a full shift wraps to all ones
    always_comb begin
        mask = (DIV_W'(1) << sel) - DIV_W'(1);
        tick = run && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + DIV_W'(1);
        end else begin
            div_q <= '0;
        end
    end

    // R9
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q == '0));

endmodule

// File: rtl/gpt_shadow.sv
module gpt_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_zero,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] cmp_in,
    output logic [CNT_W-1:0] per_eff,
    output logic [CNT_W-1:0] cmp_eff,
    output logic [CNT_W-1:0] per_hold
);
    logic [CNT_W-1:0] cmp_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_hold <= '1;
            cmp_hold <= '1;
        end else if (at_zero) begin
            per_hold <= per_in;
            cmp_hold <= cmp_in;
        end
    end

    always_comb begin
        per_eff = at_zero ? per_in : per_hold;
        cmp_eff = at_zero ? cmp_in : cmp_hold;
    end

endmodule

// File: rtl/gpt_count_fsm.sv
module gpt_count_fsm
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_in,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_eff,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             step_dn,
    output logic             run,
    output logic             updn
);
    tmr_state_e       state_q;
    tmr_state_e       state_nxt;

    // state and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_nxt;
            count_q <= cnt_nxt;
        end
    end

    // next state and next count
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = count_q;
        step_dn   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_nxt = mode_in ? ST_RISE : ST_UP;
                end
            end
            ST_UP: begin
                if (tick) begin
                    cnt_nxt = (count_q >= per_eff) ? '0 : count_q + CNT_W'(1);
                end
            end
            ST_RISE: begin
                if (tick) begin
                    if (count_q >= per_eff) begin
                        if (per_eff != '0) begin
                            cnt_nxt   = count_q - CNT_W'(1);
                            step_dn   = 1'b1;
                            state_nxt = (count_q == CNT_W'(1)) ? ST_RISE : ST_FALL;
                        end
                    end else begin
                        cnt_nxt = count_q + CNT_W'(1);
                    end
                end
            end
            ST_FALL: begin
                if (tick) begin
                    cnt_nxt = count_q - CNT_W'(1);
                    step_dn = 1'b1;
                    if (count_q == CNT_W'(1)) begin
                        state_nxt = ST_RISE;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (!enable) begin
            state_nxt = ST_IDLE;
            cnt_nxt   = '0;
            step_dn   = 1'b0;
        end
    end

    // status outputs
    always_comb begin
        run  = enable && (state_q != ST_IDLE);
        updn = (state_q == ST_RISE) || (state_q == ST_FALL);
    end

    // R1
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && enable && !tick) |=> $stable(count_q));

    // R2
    up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && count_q != '0) |-> (count_q <= per_eff));

    // R3
    fall_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FALL) |-> (count_q != '0));

    // R9
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count_q == '0 && state_q == ST_IDLE));

endmodule

// File: rtl/gpt_wave_out.sv
module gpt_wave_out #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             tick,
    input  logic             updn,
    input  logic             step_dn,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] per_eff,
    input  logic [CNT_W-1:0] cmp_eff,
    input  logic [CNT_W-1:0] per_hold,
    output logic             cmp_out,
    output logic             period_evt
);
    logic above_up;
    logic above_dn;
    logic out_nxt;

    always_comb begin
        above_up = (cnt_nxt != '0) && (cnt_nxt >= cmp_eff);
        above_dn = (cnt_nxt != '0) && (cnt_nxt > cmp_eff);
        out_nxt  = (updn && step_dn) ? above_dn : above_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_out    <= 1'b0;
            period_evt <= 1'b0;
        end else if (!run) begin
            cmp_out    <= 1'b0;
            period_evt <= 1'b0;
        end else if (tick) begin
            cmp_out    <= out_nxt;
            period_evt <= (cnt_nxt == per_eff);
        end else begin
            period_evt <= 1'b0;
        end
    end

    // R9
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!cmp_out && !period_evt));

    // R6
    evt_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_evt && count_q != '0) |-> (count_q == per_hold));

    // R4
    rise_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_out) |-> (count_q != '0));

endmodule

// File: rtl/gp_timer_cmp.sv
module gp_timer_cmp #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] prescale_sel,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] compare_in,
    input  logic             updown_mode,
    output logic [CNT_W-1:0] count_out,
    output logic             cmp_out,
    output logic             period_evt
);
    logic             tick;
    logic             run;
    logic             updn;
    logic             step_dn;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] cmp_eff;
    logic [CNT_W-1:0] per_hold;

    gpt_prescaler #(.SEL_W(SEL_W)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (prescale_sel),
        .tick  (tick)
    );

    gpt_shadow #(.CNT_W(CNT_W)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .at_zero  (count_q == '0),
        .per_in   (period_in),
        .cmp_in   (compare_in),
        .per_eff  (per_eff),
        .cmp_eff  (cmp_eff),
        .per_hold (per_hold)
    );

    gpt_count_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode_in (updown_mode),
        .tick    (tick),
        .per_eff (per_eff),
        .count_q (count_q),
        .cnt_nxt (cnt_nxt),
        .step_dn (step_dn),
        .run     (run),
        .updn    (updn)
    );

    gpt_wave_out #(.CNT_W(CNT_W)) wave_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .run        (run),
        .tick       (tick),
        .updn       (updn),
        .step_dn    (step_dn),
        .cnt_nxt    (cnt_nxt),
        .count_q    (count_q),
        .per_eff    (per_eff),
        .cmp_eff    (cmp_eff),
        .per_hold   (per_hold),
        .cmp_out    (cmp_out),
        .period_evt (period_evt)
    );

    assign count_out = count_q;

endmodule

// File: tb/gp_timer_cmp_tb_top.sv
`timescale 1ns/1ps
module gp_timer_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  prescale_sel = 3'd0;
    logic [15:0] period_in = 16'd0;
    logic [15:0] compare_in = 16'd0;
    logic        updown_mode = 1'b0;
    logic [15:0] count_out;
    logic        cmp_out;
    logic        period_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gp_timer_cmp dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .prescale_sel (prescale_sel),
        .period_in    (period_in),
        .compare_in   (compare_in),
        .updown_mode  (updown_mode),
        .count_out    (count_out),
        .cmp_out      (cmp_out),
        .period_evt   (period_evt)
    );

    typedef struct packed {
        logic        ud;
        logic [2:0]  sel;
        logic [15:0] per;
        logic [15:0] cmp;
        logic [7:0]  steps;
        logic [15:0] exp_cnt;
        logic        exp_out;
        logic        exp_evt;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'd5, 16'd7 - 16'd4, 8'd3, 16'd3, 1'b1, 1'b0},
        '{1'b0, 3'd0, 16'd5, 16'd3, 8'd5, 16'd5, 1'b1, 1'b1},
        '{1'b0, 3'd0, 16'd5, 16'd3, 8'd6, 16'd0, 1'b0, 1'b0},
        '{1'b0, 3'd2, 16'd4, 16'd2, 8'd7, 16'd2, 1'b1, 1'b0},
        '{1'b0, 3'd1, 16'd4, 16'd2, 8'd1, 16'd1, 1'b0, 1'b0},
        '{1'b1, 3'd0, 16'd4, 16'd2, 8'd2, 16'd2, 1'b1, 1'b0},
        '{1'b1, 3'd0, 16'd4, 16'd2, 8'd4, 16'd4, 1'b1, 1'b1},
        '{1'b1, 3'd0, 16'd4, 16'd2, 8'd5, 16'd3, 1'b1, 1'b0},
        '{1'b1, 3'd0, 16'd4, 16'd2, 8'd6, 16'd2, 1'b0, 1'b0},
        '{1'b1, 3'd3, 16'd3, 16'd1, 8'd9, 16'd3, 1'b1, 1'b1},
        '{1'b0, 3'd0, 16'd3, 16'd7, 8'd3, 16'd3, 1'b0, 1'b1},
        '{1'b1, 3'd0, 16'd3, 16'd3, 8'd3, 16'd3, 1'b1, 1'b1},
        '{1'b1, 3'd0, 16'd3, 16'd3, 8'd4, 16'd2, 1'b0, 1'b0},
        '{1'b0, 3'd0, 16'd0, 16'd0, 8'd4, 16'd0, 1'b0, 1'b1},
        '{1'b1, 3'd0, 16'd1, 16'd1, 8'd3, 16'd1, 1'b1, 1'b1},
        '{1'b1, 3'd0, 16'd1, 16'd1, 8'd2, 16'd0, 1'b0, 1'b0},
        '{1'b1, 3'd0, 16'd0, 16'd0, 8'd3, 16'd0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic ud, input logic [2:0] sel,
                         input logic [15:0] per, input logic [15:0] cmp);
        @(negedge clk);
        enable = 1'b0;
        updown_mode = ud;
        prescale_sel = sel;
        period_in = per;
        compare_in = cmp;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(posedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10 reset state
        edges(3);
        check("R10", "count in reset", count_out, 0);
        check("R10", "cmp in reset", cmp_out, 0);
        rst_n = 1'b1;
        edges(2);
        check("R10", "count after reset", count_out, 0);
        check("R10", "cmp after reset", cmp_out, 0);
        check("R10", "evt after reset", period_evt, 0);

        // vector table: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            start(VECS[v].ud, VECS[v].sel, VECS[v].per, VECS[v].cmp);
            edges(int'(VECS[v].steps) << VECS[v].sel);
            check(VECS[v].ud ? "R3" : "R2", $sformatf("vec %0d count", v),
                  count_out, VECS[v].exp_cnt);
            check(VECS[v].ud ? "R5" : "R4", $sformatf("vec %0d cmp", v),
                  cmp_out, VECS[v].exp_out);
            check("R6", $sformatf("vec %0d evt", v), period_evt, VECS[v].exp_evt);
        end

        // R1 hold between ticks with divide by 4
        start(1'b0, 3'd2, 16'd9, 16'd5);
        edges(4);
        check("R1", "first step at 4 clocks", count_out, 1);
        edges(3);
        check("R1", "held between ticks", count_out, 1);
        edges(1);
        check("R1", "second step", count_out, 2);

        // R6 pulse lasts one clock
        start(1'b0, 3'd1, 16'd2, 16'd1);
        edges(4);
        check("R6", "evt on reaching period", period_evt, 1);
        edges(1);
        check("R6", "evt cleared next clock", period_evt, 0);
        check("R6", "count still at period", count_out, 2);

        // R7 shadowing of period and compare
        start(1'b0, 3'd0, 16'd5, 16'd3);
        edges(2);
        period_in = 16'd2;
        compare_in = 16'd1;
        edges(3);
        check("R7", "old period still in force", count_out, 5);
        check("R7", "evt at old period", period_evt, 1);
        edges(1);
        check("R7", "wrap to zero", count_out, 0);
        edges(1);
        check("R7", "new compare applied", cmp_out, 1);
        edges(1);
        check("R7", "new period evt", period_evt, 1);
        edges(1);
        check("R7", "wrap at new period", count_out, 0);

        // R8 mode change while running ignored
        start(1'b0, 3'd0, 16'd3, 16'd9);
        edges(1);
        updown_mode = 1'b1;
        edges(3);
        check("R8", "saw-tooth kept", count_out, 0);

        // R9 disable and restart
        start(1'b0, 3'd0, 16'd5, 16'd1);
        edges(3);
        check("R9", "running before disable", count_out, 3);
        enable = 1'b0;
        edges(1);
        check("R9", "count cleared", count_out, 0);
        check("R9", "cmp cleared", cmp_out, 0);
        edges(5);
        check("R9", "count held while disabled", count_out, 0);
        prescale_sel = 3'd1;
        enable = 1'b1;
        edges(2);
        check("R9", "divider restarted", count_out, 0);
        edges(1);
        check("R9", "first step after restart", count_out, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule